// File: doc/BRIEF.md
# Stack Machine Branch Decision Unit

This block decides the next program counter and the stack strobes for the branch-class instructions of a stack processor that keeps its top two data-stack cells in registers. Each cycle that `in_valid_i` is high it takes a condition code, a stack action, a flag telling whether the previous instruction was a literal, the top-of-stack value, the current program counter, the top of the return stack and the overflow and carry flags. One clock later it presents the chosen next PC and the strobes for the data stack, the return stack and the status register.

The stack action selects the kind of transfer: a conditional return, a conditional branch, a conditional call, or one of a small group of complex operations. The literal flag selects whether a branch or call target is the absolute address held in TOS or the current PC plus TOS. User traps ignore the condition and action fields and call a vector whose address is the trap number times a parameter giving the instruction slots per vector. Instruction fetch, memories and the ALU belong to other blocks; this unit only produces decisions and strobes.

Top module: `stk_branch_unit`

## Requirements
- R1: After reset `out_valid_o`, `taken_o`, every strobe, `next_pc_o` and `rs_data_o` read zero.
- R2: Results for a request accepted with `in_valid_i` high appear exactly one clock later with `out_valid_o` high; with no request, `out_valid_o`, `taken_o` and all strobes are low. `rs_data_o` always carries the request's PC plus one.
- R3: Condition codes are NEVER=0 (false), ALWAYS=1 (true), ZERO=2 (TOS equals zero), NZERO=3 (TOS non-zero), SIGN=4 (TOS bit DW-1 set), NSIGN=5 (that bit clear), NOVL=6 (overflow flag clear), NCARRY=7 (carry flag clear); a false condition gives next PC = PC+1 with `taken_o` low.
- R4: Stack action 0 is a conditional return: when the condition holds, next PC is `rtop_i`, `rs_pop_o` and `taken_o` are set; the data stack is not popped.
- R5: Stack action 1 is a conditional branch; it raises `ds_pop_o` whatever the condition, and a true condition sets next PC to the target and `taken_o`.
- R6: With `lit_prev_i` low the target is TOS bits [AW-1:0]; with it high the target is PC + TOS bits [AW-1:0], modulo 2^AW.
- R7: Stack action 3 is a conditional call: `ds_pop_o` is raised whatever the condition, and a true condition sets next PC to the target, `taken_o` and `rs_push_o`; return-stack push and pop are never raised together.
- R8: With `is_trap_i` high the unit calls address `trap_num_i` × SLOTS (`taken_o`, `rs_push_o`), ignores condition and action, and touches no data-stack strobe.
- R9: Stack action 2 with code 0 duplicates TOS (`ds_push_o`); with code 2 it raises `ds_push_o` only when TOS is non-zero; both continue at PC+1.
- R10: Stack action 2 with code 1 calls vector 2 (exception routine); with code 4 it calls vector 1 (interrupt routine) and also raises `ds_push_o` to save the status word. Vector n lies at n × SLOTS.
- R11: Stack action 2 with code 3 calls vector 3 (overflow routine) only when `ovl_i` is high, otherwise continues at PC+1 with no strobe.
- R12: Stack action 2 with code 5 returns to `rtop_i` with `rs_pop_o`, raises `status_load_o` and pops TOS (`ds_pop_o`).
- R13: Stack action 2 with codes 6 and 7 continues at PC+1 and raises no strobe and no `taken_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Request present this cycle |
| is_trap_i | input | 1 | Request is a user trap |
| trap_num_i | input | 5 | Trap vector number |
| cond_i | input | 3 | Condition code, or complex-operation code when action is 2 |
| act_i | input | 2 | Stack action: 0 return, 1 branch, 2 complex, 3 call |
| lit_prev_i | input | 1 | Previous instruction was a literal (relative target) |
| tos_i | input | DW | Top of data stack |
| pc_i | input | AW | Address of the current instruction |
| rtop_i | input | AW | Top of return stack |
| ovl_i | input | 1 | Overflow status flag |
| carry_i | input | 1 | Carry status flag |
| out_valid_o | output | 1 | Decision valid |
| next_pc_o | output | AW | Next program counter |
| taken_o | output | 1 | Control left the sequential path |
| ds_pop_o | output | 1 | Pop data stack |
| ds_push_o | output | 1 | Push data stack |
| rs_push_o | output | 1 | Push return stack |
| rs_pop_o | output | 1 | Pop return stack |
| status_load_o | output | 1 | Load status register from TOS |
| rs_data_o | output | AW | Return address (request PC plus one) |

## Verification
Every stack action is crossed with all eight condition codes over TOS values of zero, a small positive number, a value with only the top bit set and a negative value, so that each condition's true and false side is hit and zero and sign tests are told apart. Both settings of the literal flag are applied for every transfer, which separates absolute from relative targets, and a negative TOS with a large PC exercises wrap-around of the relative adder. Overflow and carry are driven both low and high to split NOVL, NCARRY and the overflow trap, and user traps with numbers 0, 1, 5 and 31 under mixed condition and action fields show that those fields are ignored.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  typedef enum logic [2:0] {
    CC_NEVER, CC_ALWAYS, CC_ZERO, CC_NZERO,
    CC_SIGN, CC_NSIGN, CC_NOVL, CC_NCARRY
  } cond_e;

  typedef enum logic [1:0] {
    ACT_RET, ACT_BRANCH, ACT_CPLX, ACT_CALL
  } act_e;

  typedef enum logic [2:0] {
    CX_DUP, CX_EXC, CX_QDUP, CX_QOVL,
    CX_INT, CX_IRET, CX_RSV6, CX_RSV7
  } cplx_e;

  localparam logic [4:0] VEC_ISR = 5'd1;
  localparam logic [4:0] VEC_ESR = 5'd2;
  localparam logic [4:0] VEC_OVL = 5'd3;

  typedef struct packed {
    logic taken;
    logic ds_pop;
    logic ds_push;
    logic rs_push;
    logic rs_pop;
    logic st_load;
  } strobe_t;

  // condition evaluation on pre-decoded flags
  function automatic logic cond_true(input logic [2:0] code, input logic is_zero,
                                     input logic is_neg, input logic ov, input logic cy);
    logic r;
    case (cond_e'(code))
      CC_NEVER:  r = 1'b0;
      CC_ALWAYS: r = 1'b1;
      CC_ZERO:   r = is_zero;
      CC_NZERO:  r = !is_zero;
      CC_SIGN:   r = is_neg;
      CC_NSIGN:  r = !is_neg;
      CC_NOVL:   r = !ov;
      default:   r = !cy;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sbu_cond.sv
module sbu_cond #(
  parameter int DW = 16
) (
  input  logic [2:0]    code_i,
  input  logic [DW-1:0] tos_i,
  input  logic          ovl_i,
  input  logic          carry_i,
  output logic          met_o,
  output logic          tos_zero_o
);
  import sbu_pkg::*;

  logic tos_neg;

  assign tos_zero_o = (tos_i == '0);
  assign tos_neg    = tos_i[DW-1];
  assign met_o      = cond_true(code_i, tos_zero_o, tos_neg, ovl_i, carry_i);

endmodule

// File: rtl/sbu_target.sv
module sbu_target #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int SLOTS = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] tos_i,
  input  logic          lit_prev_i,
  input  logic [4:0]    trap_num_i,
  output logic [AW-1:0] seq_pc_o,
  output logic [AW-1:0] flow_tgt_o,
  output logic [AW-1:0] vec_trap_o,
  output logic [AW-1:0] vec_isr_o,
  output logic [AW-1:0] vec_esr_o,
  output logic [AW-1:0] vec_ovl_o
);
  import sbu_pkg::*;

  logic [AW-1:0] tos_addr;

  // TOS narrowed or widened to an address
  generate
    if (DW >= AW) begin : g_slice
      assign tos_addr = tos_i[AW-1:0];
    end else begin : g_extend
      assign tos_addr = {{(AW-DW){1'b0}}, tos_i};
    end
  endgenerate

  function automatic logic [AW-1:0] vec_addr(input logic [4:0] n);
    return AW'(n) * AW'(SLOTS);
  endfunction

  function automatic logic [AW-1:0] rel_addr(input logic [AW-1:0] base, input logic [AW-1:0] off);
    return base + off;
  endfunction

  assign seq_pc_o   = rel_addr(pc_i, AW'(1));
  assign flow_tgt_o = lit_prev_i ? rel_addr(pc_i, tos_addr) : tos_addr;
  assign vec_trap_o = vec_addr(trap_num_i);
  assign vec_isr_o  = vec_addr(VEC_ISR);
  assign vec_esr_o  = vec_addr(VEC_ESR);
  assign vec_ovl_o  = vec_addr(VEC_OVL);

endmodule

// File: rtl/sbu_ctrl.sv
module sbu_ctrl #(
  parameter int AW = 12
) (
  input  logic             is_trap_i,
  input  logic [1:0]       act_i,
  input  logic [2:0]       code_i,
  input  logic             met_i,
  input  logic             tos_zero_i,
  input  logic             ovl_i,
  input  logic [AW-1:0]    rtop_i,
  input  logic [AW-1:0]    seq_pc_i,
  input  logic [AW-1:0]    flow_tgt_i,
  input  logic [AW-1:0]    vec_trap_i,
  input  logic [AW-1:0]    vec_isr_i,
  input  logic [AW-1:0]    vec_esr_i,
  input  logic [AW-1:0]    vec_ovl_i,
  output logic [AW-1:0]    nxt_pc_o,
  output sbu_pkg::strobe_t st_o
);
  import sbu_pkg::*;

  always_comb begin
    nxt_pc_o = seq_pc_i;
    st_o     = '0;
    if (is_trap_i) begin
      nxt_pc_o      = vec_trap_i;
      st_o.taken    = 1'b1;
      st_o.rs_push  = 1'b1;
    end else begin
      case (act_e'(act_i))
        ACT_RET: begin
          if (met_i) begin
            nxt_pc_o    = rtop_i;
            st_o.taken  = 1'b1;
            st_o.rs_pop = 1'b1;
          end
        end
        ACT_BRANCH: begin
          st_o.ds_pop = 1'b1;
          if (met_i) begin
            nxt_pc_o   = flow_tgt_i;
            st_o.taken = 1'b1;
          end
        end
        ACT_CALL: begin
          st_o.ds_pop = 1'b1;
          if (met_i) begin
            nxt_pc_o     = flow_tgt_i;
            st_o.taken   = 1'b1;
            st_o.rs_push = 1'b1;
          end
        end
        default: begin
          case (cplx_e'(code_i))
            CX_DUP:  st_o.ds_push = 1'b1;
            CX_QDUP: st_o.ds_push = !tos_zero_i;
            CX_EXC: begin
              nxt_pc_o     = vec_esr_i;
              st_o.taken   = 1'b1;
              st_o.rs_push = 1'b1;
            end
            CX_QOVL: begin
              if (ovl_i) begin
                nxt_pc_o     = vec_ovl_i;
                st_o.taken   = 1'b1;
                st_o.rs_push = 1'b1;
              end
            end
            CX_INT: begin
              nxt_pc_o     = vec_isr_i;
              st_o.taken   = 1'b1;
              st_o.rs_push = 1'b1;
              st_o.ds_push = 1'b1;
            end
            CX_IRET: begin
              nxt_pc_o     = rtop_i;
              st_o.taken   = 1'b1;
              st_o.rs_pop  = 1'b1;
              st_o.st_load = 1'b1;
              st_o.ds_pop  = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/stk_branch_unit.sv
module stk_branch_unit #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int SLOTS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  logic          is_trap_i,
  input  logic [4:0]    trap_num_i,
  input  logic [2:0]    cond_i,
  input  logic [1:0]    act_i,
  input  logic          lit_prev_i,
  input  logic [DW-1:0] tos_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] rtop_i,
  input  logic          ovl_i,
  input  logic          carry_i,
  output logic          out_valid_o,
  output logic [AW-1:0] next_pc_o,
  output logic          taken_o,
  output logic          ds_pop_o,
  output logic          ds_push_o,
  output logic          rs_push_o,
  output logic          rs_pop_o,
  output logic          status_load_o,
  output logic [AW-1:0] rs_data_o
);
  import sbu_pkg::*;

  // named internal events
  logic          cond_met;
  logic          tos_zero;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] flow_tgt;
  logic [AW-1:0] vec_trap;
  logic [AW-1:0] vec_isr;
  logic [AW-1:0] vec_esr;
  logic [AW-1:0] vec_ovl;
  logic [AW-1:0] nxt_pc;
  strobe_t       strobes;
  strobe_t       strobes_q;

  sbu_cond #(.DW(DW)) u_cond (
    .code_i     (cond_i),
    .tos_i      (tos_i),
    .ovl_i      (ovl_i),
    .carry_i    (carry_i),
    .met_o      (cond_met),
    .tos_zero_o (tos_zero)
  );

  sbu_target #(.DW(DW), .AW(AW), .SLOTS(SLOTS)) u_target (
    .pc_i       (pc_i),
    .tos_i      (tos_i),
    .lit_prev_i (lit_prev_i),
    .trap_num_i (trap_num_i),
    .seq_pc_o   (seq_pc),
    .flow_tgt_o (flow_tgt),
    .vec_trap_o (vec_trap),
    .vec_isr_o  (vec_isr),
    .vec_esr_o  (vec_esr),
    .vec_ovl_o  (vec_ovl)
  );

  sbu_ctrl #(.AW(AW)) u_ctrl (
    .is_trap_i  (is_trap_i),
    .act_i      (act_i),
    .code_i     (cond_i),
    .met_i      (cond_met),
    .tos_zero_i (tos_zero),
    .ovl_i      (ovl_i),
    .rtop_i     (rtop_i),
    .seq_pc_i   (seq_pc),
    .flow_tgt_i (flow_tgt),
    .vec_trap_i (vec_trap),
    .vec_isr_i  (vec_isr),
    .vec_esr_i  (vec_esr),
    .vec_ovl_i  (vec_ovl),
    .nxt_pc_o   (nxt_pc),
    .st_o       (strobes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      next_pc_o   <= '0;
      rs_data_o   <= '0;
      strobes_q   <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      strobes_q   <= in_valid_i ? strobes : '0;
      if (in_valid_i) begin
        next_pc_o <= nxt_pc;
        rs_data_o <= seq_pc;
      end
    end
  end

  assign taken_o       = strobes_q.taken;
  assign ds_pop_o      = strobes_q.ds_pop;
  assign ds_push_o     = strobes_q.ds_push;
  assign rs_push_o     = strobes_q.rs_push;
  assign rs_pop_o      = strobes_q.rs_pop;
  assign status_load_o = strobes_q.st_load;

endmodule

// File: rtl/sbu_chk.sv
module sbu_chk #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int SLOTS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid_i,
  input logic          is_trap_i,
  input logic [4:0]    trap_num_i,
  input logic [1:0]    act_i,
  input logic [DW-1:0] tos_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] rtop_i,
  input logic          out_valid_o,
  input logic [AW-1:0] next_pc_o,
  input logic          taken_o,
  input logic          ds_pop_o,
  input logic          ds_push_o,
  input logic          rs_push_o,
  input logic          rs_pop_o,
  input logic          status_load_o,
  input logic [AW-1:0] rs_data_o,
  input logic          cond_met
);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid_o |-> !(taken_o || ds_pop_o || ds_push_o || rs_push_o || rs_pop_o || status_load_o));

  a_r3_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !taken_o) |-> next_pc_o == AW'($past(pc_i) + AW'(1)));

  a_r4_return_pc: assert property (@(posedge clk) disable iff (rst)
    rs_pop_o |-> next_pc_o == $past(rtop_i));

  a_r5_branch_pops: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid_i && !is_trap_i && act_i == 2'd1) |-> ds_pop_o);

  a_r4_no_taken_without_cond: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid_i && !is_trap_i && act_i == 2'd0 && !cond_met) |-> !taken_o);

  a_r7_link_addr: assert property (@(posedge clk) disable iff (rst)
    rs_push_o |-> rs_data_o == AW'($past(pc_i) + AW'(1)));

  a_r7_rs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rs_push_o && rs_pop_o));

  a_r8_trap_vector: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid_i && is_trap_i) |-> (next_pc_o == AW'(AW'($past(trap_num_i)) * AW'(SLOTS))
                                        && rs_push_o && !ds_pop_o && !ds_push_o));

  a_r12_iret_pair: assert property (@(posedge clk) disable iff (rst)
    status_load_o |-> (rs_pop_o && ds_pop_o));

endmodule

bind stk_branch_unit sbu_chk #(.DW(DW), .AW(AW), .SLOTS(SLOTS)) u_sbu_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid_i    (in_valid_i),
  .is_trap_i     (is_trap_i),
  .trap_num_i    (trap_num_i),
  .act_i         (act_i),
  .tos_i         (tos_i),
  .pc_i          (pc_i),
  .rtop_i        (rtop_i),
  .out_valid_o   (out_valid_o),
  .next_pc_o     (next_pc_o),
  .taken_o       (taken_o),
  .ds_pop_o      (ds_pop_o),
  .ds_push_o     (ds_push_o),
  .rs_push_o     (rs_push_o),
  .rs_pop_o      (rs_pop_o),
  .status_load_o (status_load_o),
  .rs_data_o     (rs_data_o),
  .cond_met      (cond_met)
);

// File: tb/tb_stk_branch_unit.sv
`timescale 1ns/1ps
module tb_stk_branch_unit;
  localparam int DW    = 16;
  localparam int AW    = 12;
  localparam int SLOTS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid_i = 1'b0;
  logic          is_trap_i = 1'b0;
  logic [4:0]    trap_num_i = '0;
  logic [2:0]    cond_i = '0;
  logic [1:0]    act_i = '0;
  logic          lit_prev_i = 1'b0;
  logic [DW-1:0] tos_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic [AW-1:0] rtop_i = '0;
  logic          ovl_i = 1'b0;
  logic          carry_i = 1'b0;
  logic          out_valid_o;
  logic [AW-1:0] next_pc_o;
  logic          taken_o, ds_pop_o, ds_push_o, rs_push_o, rs_pop_o, status_load_o;
  logic [AW-1:0] rs_data_o;

  always #4 clk = ~clk;

  stk_branch_unit #(.DW(DW), .AW(AW), .SLOTS(SLOTS)) dut (.*);

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [AW-1:0] link;
    logic          tk, dpop, dpush, rpush, rpop, stl;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // independent reference of the requirements
  function automatic exp_t model(input logic trap, input logic [4:0] tn, input logic [2:0] c,
                                 input logic [1:0] a, input logic lit, input logic [DW-1:0] tos,
                                 input logic [AW-1:0] pc, input logic [AW-1:0] rt,
                                 input logic ov, input logic cy);
    exp_t e;
    logic [7:0] tbl;
    logic ok;
    logic [AW-1:0] dest;
    tbl  = {!cy, !ov, !tos[DW-1], tos[DW-1], (tos != 0), (tos == 0), 1'b1, 1'b0};
    ok   = tbl[c];
    dest = lit ? AW'(pc + tos[AW-1:0]) : tos[AW-1:0];
    e = '0;
    e.link = AW'(pc + 1);
    e.pc   = e.link;
    if (trap) begin
      e.pc = AW'(tn * SLOTS); e.tk = 1; e.rpush = 1;
    end else if (a == 2'd0) begin
      if (ok) begin e.pc = rt; e.tk = 1; e.rpop = 1; end
    end else if (a == 2'd1 || a == 2'd3) begin
      e.dpop = 1;
      if (ok) begin e.pc = dest; e.tk = 1; e.rpush = (a == 2'd3); end
    end else begin
      if (c == 3'd0) e.dpush = 1;
      if (c == 3'd2) e.dpush = (tos != 0);
      if (c == 3'd1) begin e.pc = AW'(2 * SLOTS); e.tk = 1; e.rpush = 1; end
      if (c == 3'd3 && ov) begin e.pc = AW'(3 * SLOTS); e.tk = 1; e.rpush = 1; end
      if (c == 3'd4) begin e.pc = AW'(SLOTS); e.tk = 1; e.rpush = 1; e.dpush = 1; end
      if (c == 3'd5) begin e.pc = rt; e.tk = 1; e.rpop = 1; e.stl = 1; e.dpop = 1; end
    end
    return e;
  endfunction

  task automatic apply(input string tag, input logic trap, input logic [4:0] tn,
                       input logic [2:0] c, input logic [1:0] a, input logic lit,
                       input logic [DW-1:0] tos, input logic [AW-1:0] pc,
                       input logic [AW-1:0] rt, input logic ov, input logic cy);
    @(negedge clk);
    in_valid_i = 1'b1; is_trap_i = trap; trap_num_i = tn; cond_i = c; act_i = a;
    lit_prev_i = lit; tos_i = tos; pc_i = pc; rtop_i = rt; ovl_i = ov; carry_i = cy;
    expq.push_back(model(trap, tn, c, a, lit, tos, pc, rt, ov, cy));
    tagq.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid_i = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst && !done && out_valid_o) begin
      exp_t  e;
      exp_t  got;
      string t;
      n_chk++;
      got = {next_pc_o, rs_data_o, taken_o, ds_pop_o, ds_push_o, rs_push_o, rs_pop_o, status_load_o};
      if (expq.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected result: got %h expected none", got);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        if (got !== e)
          $display("FAIL %s: got pc=%h link=%h tk%b dp%b du%b rp%b ro%b sl%b expected pc=%h link=%h tk%b dp%b du%b rp%b ro%b sl%b",
                   t, got.pc, got.link, got.tk, got.dpop, got.dpush, got.rpush, got.rpop, got.stl,
                   e.pc, e.link, e.tk, e.dpop, e.dpush, e.rpush, e.rpop, e.stl);
        if (got !== e) n_fail++;
      end
    end
  end

  task automatic check_quiet(input string tag);
    logic [6:0] v;
    v = {out_valid_o, taken_o, ds_pop_o, ds_push_o, rs_push_o, rs_pop_o, status_load_o};
    n_chk++;
    if (v !== '0) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected 0000000", tag, v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] tv [4];
    tv[0] = 16'h0000; tv[1] = 16'h0005; tv[2] = 16'h8000; tv[3] = 16'hFFF3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    n_chk++;
    if (next_pc_o !== '0 || rs_data_o !== '0) begin
      n_fail++;
      $display("FAIL R1: pc=%h link=%h expected 000 000", next_pc_o, rs_data_o);
    end
    check_quiet("R1");

    // R3 R4 R5 R6 R7 R9..R13 sweep
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 8; c++)
        for (int t = 0; t < 4; t++)
          for (int f = 0; f < 4; f++) begin
            string tag;
            case (a)
              0: tag = "R4/R3";
              1: tag = "R5/R6/R3";
              3: tag = "R7/R6/R3";
              default: case (c)
                0, 2: tag = "R9";
                1, 4: tag = "R10";
                3: tag = "R11";
                5: tag = "R12";
                default: tag = "R13";
              endcase
            endcase
            apply(tag, 1'b0, 5'd0, 3'(c), 2'(a), f[0], tv[t],
                  AW'(12'hFF0 + 12'(t * 3 + c)), AW'(12'h3A0 + 12'(c)), f[1], f[0] ^ f[1]);
          end

    // R8: traps ignore condition and action
    apply("R8", 1'b1, 5'd0,  3'd2, 2'd1, 1'b1, 16'h0000, 12'h100, 12'h222, 1'b0, 1'b0);
    apply("R8", 1'b1, 5'd1,  3'd5, 2'd2, 1'b0, 16'h0040, 12'h101, 12'h222, 1'b1, 1'b1);
    apply("R8", 1'b1, 5'd5,  3'd1, 2'd0, 1'b1, 16'h8001, 12'h102, 12'h222, 1'b0, 1'b1);
    apply("R8", 1'b1, 5'd31, 3'd0, 2'd3, 1'b0, 16'h0007, 12'hFFF, 12'h222, 1'b1, 1'b0);

    // R2: gap then a single request
    idle(3);
    check_quiet("R2");
    apply("R2/R7", 1'b0, 5'd0, 3'd1, 2'd3, 1'b1, 16'h0010, 12'h7FF, 12'h000, 1'b0, 1'b0);
    idle(3);
    check_quiet("R2");
    n_chk++;
    if (expq.size() != 0) begin
      n_fail++;
      $display("FAIL R2: got %0d pending expected 0", expq.size());
    end
    finish_run();
  end

endmodule